// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the clock and data lines of a two-wire SMBus port and flags two fault conditions. The first is an idle-bus timeout: both lines have sat high for longer than a fixed number of clock-source ticks. The monitor treats that condition as if a STOP condition had been seen. It emits a one-cycle free event, sets a sticky stop flag and raises a sticky interrupt request. The second is a clock-stretch timeout: SCL has been held low for a programmable number of system clocks. The monitor then emits a one-cycle event that tells the surrounding interface to reset itself by disabling and re-enabling.

Both raw lines pass through two-flop synchronisers before any counting is done. Each detector has its own enable. The low-timeout limit is a run-time input counted in system clocks, so a real configuration can set about 25 ms while a test uses a handful of cycles. The sticky flags stay set until the clear input is pulsed.

Top module: `smb_tmo_mon`

## Requirements
- R1: `scl_in` and `sda_in` reach the counters only through a two-flop synchroniser whose flops reset to 1. A change at a pin affects the counters two clock edges later.
- R2: With `free_en`=1 and both synchronised lines high, `free_evt` pulses for one cycle on the clock edge of the 11th `tick` (FREE_TICKS+1 with the default FREE_TICKS=10) counted since the lines last became idle.
- R3: Any synchronised low level on SCL or SDA clears the idle tick count. A new idle period needs a full 11 ticks again.
- R4: Only one `free_evt` is produced per idle period, however many further ticks arrive.
- R5: With `free_en`=0, `free_evt` never asserts and the idle count is held at zero.
- R6: `stop_flag` and `irq` become 1 on the clock edge after a `free_evt` pulse. They stay 1 until `flag_clr` is high on a clock edge. A set on that same edge takes priority over the clear.
- R7: The low counter is reloaded to zero while synchronised SCL is high and counts one per system clock while it is low. Measured from the edge at which `scl_in` is first sampled low, `low_evt` pulses on edge number `low_limit`+2.
- R8: With `low_en`=0, `low_evt` never asserts.
- R9: `low_evt` pulses only once per low period. It sets `irq` on the next edge and leaves `stop_flag` unchanged.
- R10: A `low_limit` of 0 disables the low timeout: `low_evt` never asserts.
- R11: While `rst_n` is low, all counters, `free_evt`, `low_evt`, `stop_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per clock-source period |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| free_en | input | 1 | Enable idle-bus timeout detection |
| low_en | input | 1 | Enable SCL-low timeout detection |
| low_limit | input | LIMIT_W | SCL-low limit in system clocks; 0 disables |
| flag_clr | input | 1 | Clears `stop_flag` and `irq` |
| free_evt | output | 1 | One-cycle idle-timeout event (synthetic STOP) |
| stop_flag | output | 1 | Sticky STOP-detected flag |
| irq | output | 1 | Sticky interrupt request |
| low_evt | output | 1 | One-cycle SCL-low timeout event, request to reset the interface |

## Verification
The hardest condition to reach from the ports is an idle period that is interrupted at an exact tick count. The test must show that the count really returns to zero rather than simply pausing. The bench sweeps the break point over every tick from 1 to 10. At each break point it drops SDA long enough to pass through the synchroniser, restores it, and then requires exactly 11 further ticks before the event. A similar sweep over small `low_limit` values measures the pin-to-event latency edge by edge. It also releases SCL partway through a count to prove that the counter reloads.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

  // Pair of bus line levels as seen at the pins or after synchronising.
  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

  // Idle detector fires on the tick that arrives once `seen` ticks were
  // already counted and that count equals the threshold.
  function automatic logic free_hit(input logic [31:0] seen, input logic [31:0] thr);
    return seen == thr;
  endfunction

  // Low detector fires when the count reaches limit-1 before the edge;
  // a zero limit never fires.
  function automatic logic low_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (lim != 32'd0) && (cnt == lim - 32'd1);
  endfunction

endpackage

// File: rtl/smb_sync2.sv
module smb_sync2 #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta <= RST_VAL[i];
        q[i] <= RST_VAL[i];
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/smb_free_timer.sv
module smb_free_timer
  import smb_tmo_pkg::*;
#(
  parameter int unsigned TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic idle,
  input  logic tick,
  output logic evt
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;
  logic          fired;
  logic          hit;

  assign hit = en && idle && tick && !fired && free_hit(32'(cnt), TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
      evt   <= 1'b0;
    end else begin
      evt <= hit;
      if (!en || !idle) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (tick && !fired) begin
        if (hit) fired <= 1'b1;
        else     cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer
  import smb_tmo_pkg::*;
#(
  parameter int unsigned LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          scl_hi,
  input  logic [LW-1:0] limit,
  output logic          evt
);
  logic [LW-1:0] cnt;
  logic          done;
  logic          hit;

  assign hit = en && !scl_hi && !done && low_hit(32'(cnt), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      evt  <= 1'b0;
    end else begin
      evt <= hit;
      if (!en || scl_hi) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (!done) begin
        cnt <= cnt + 1'b1;
        if (hit) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_tmo_mon.sv
module smb_tmo_mon
  import smb_tmo_pkg::*;
#(
  parameter int unsigned FREE_TICKS = 10,
  parameter int unsigned LIMIT_W    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               free_en,
  input  logic               low_en,
  input  logic [LIMIT_W-1:0] low_limit,
  input  logic               flag_clr,
  output logic               free_evt,
  output logic               stop_flag,
  output logic               irq,
  output logic               low_evt
);
  localparam int unsigned NLINES = $bits(bus_lines_t);

  bus_lines_t raw_lines;
  bus_lines_t sync_lines;
  logic       scl_s;
  logic       sda_s;
  logic       bus_idle;

  assign raw_lines = '{scl: scl_in, sda: sda_in};

  smb_sync2 #(.W(NLINES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_lines),
    .q    (sync_lines)
  );

  assign scl_s    = sync_lines.scl;
  assign sda_s    = sync_lines.sda;
  assign bus_idle = scl_s && sda_s;

  smb_free_timer #(.TICKS(FREE_TICKS)) u_free (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (free_en),
    .idle (bus_idle),
    .tick (tick),
    .evt  (free_evt)
  );

  smb_low_timer #(.LW(LIMIT_W)) u_low (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (low_en),
    .scl_hi(scl_s),
    .limit (low_limit),
    .evt   (low_evt)
  );

  // Sticky flags: a set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      stop_flag <= (stop_flag && !flag_clr) || free_evt;
      irq       <= (irq && !flag_clr) || free_evt || low_evt;
    end
  end
endmodule

// File: rtl/smb_tmo_chk.sv
module smb_tmo_chk #(
  parameter int unsigned LIMIT_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               free_en,
  input logic               low_en,
  input logic [LIMIT_W-1:0] low_limit,
  input logic               flag_clr,
  input logic               scl_s,
  input logic               sda_s,
  input logic               free_evt,
  input logic               stop_flag,
  input logic               irq,
  input logic               low_evt
);
  // R2
  free_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_evt |-> $past(tick) && $past(free_en));
  // R3
  free_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_evt |-> $past(scl_s) && $past(sda_s));
  // R4
  free_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_evt |=> !free_evt);
  // R6
  stop_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_flag) |-> $past(free_evt));
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !free_evt && !low_evt) |=> !irq && !stop_flag);
  // R7
  low_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |-> !$past(scl_s) && $past(low_en));
  // R9
  low_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |=> !low_evt);
  // R10
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_evt |-> $past(low_limit) != '0);
endmodule

bind smb_tmo_mon smb_tmo_chk #(.LIMIT_W(LIMIT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .free_en  (free_en),
  .low_en   (low_en),
  .low_limit(low_limit),
  .flag_clr (flag_clr),
  .scl_s    (scl_s),
  .sda_s    (sda_s),
  .free_evt (free_evt),
  .stop_flag(stop_flag),
  .irq      (irq),
  .low_evt  (low_evt)
);

// File: tb/smb_tmo_mon_test.sv
module smb_tmo_mon_test;
  localparam int FT = 10;
  localparam int LW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic free_en = 1'b0, low_en = 1'b0, flag_clr = 1'b0;
  logic [LW-1:0] low_limit = '0;
  logic free_evt, stop_flag, irq, low_evt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  smb_tmo_mon #(.FREE_TICKS(FT), .LIMIT_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scl_in(scl_in), .sda_in(sda_in),
    .free_en(free_en), .low_en(low_en), .low_limit(low_limit), .flag_clr(flag_clr),
    .free_evt(free_evt), .stop_flag(stop_flag), .irq(irq), .low_evt(low_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(posedge clk);
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) flag_clr = 1'b1;
    @(posedge clk);
    @(negedge clk) flag_clr = 1'b0;
  endtask

  // Ticks until the first free event; expects FT+1 and a single pulse.
  task automatic free_run(input string tag);
    int first = 0;
    int pulses = 0;
    for (int k = 1; k <= FT + 4; k++) begin
      tick_once();
      if (free_evt) begin
        pulses++;
        if (first == 0) begin
          first = k;
          check({tag, " R6 stop not yet set"}, stop_flag, 0);
        end
      end
    end
    check({tag, " R2 fire tick"}, first, FT + 1);
    check({tag, " R4 pulses"}, pulses, 1);
    check({tag, " R6 stop_flag"}, stop_flag, 1);
    check({tag, " R6 irq"}, irq, 1);
  endtask

  // Drop SCL, count edges to low_evt.
  task automatic low_case(input int lim);
    int first = 0;
    int pulses = 0;
    @(negedge clk) begin low_limit = LW'(lim); scl_in = 1'b0; end
    for (int n = 1; n <= lim + 8; n++) begin
      @(posedge clk); @(negedge clk);
      if (low_evt) begin
        pulses++;
        if (first == 0) begin
          first = n;
          check("R9 irq before set", irq, 0);
        end
      end
    end
    check($sformatf("R1 R7 latency lim=%0d", lim), first, lim + 2);
    check("R9 pulses", pulses, 1);
    check("R9 irq set", irq, 1);
    check("R9 stop untouched", stop_flag, 0);
    scl_in = 1'b1;
    cyc(4);
    clear_flags();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    // R11 reset state
    cyc(3);
    check("R11 free_evt", free_evt, 0);
    check("R11 stop_flag", stop_flag, 0);
    check("R11 irq", irq, 0);
    check("R11 low_evt", low_evt, 0);
    rst_n = 1'b1;
    cyc(2);

    // R2 R4 R6: plain idle period
    free_en = 1'b1;
    cyc(3);
    free_run("idle");
    clear_flags();
    check("R6 clear stop", stop_flag, 0);
    check("R6 clear irq", irq, 0);

    // R3: break idle after every tick count 1..10, alternating line
    for (int b = 1; b <= FT; b++) begin
      sda_in = 1'b0; scl_in = 1'b0;
      cyc(4);
      scl_in = 1'b1; sda_in = 1'b1;
      cyc(3);
      cnt = 0;
      for (int k = 0; k < b; k++) begin tick_once(); if (free_evt) cnt++; end
      check($sformatf("R3 no early event b=%0d", b), cnt, 0);
      if (b % 2 == 0) sda_in = 1'b0; else scl_in = 1'b0;
      cyc(4);
      scl_in = 1'b1; sda_in = 1'b1;
      cyc(3);
      free_run($sformatf("R3 restart b=%0d", b));
      clear_flags();
    end

    // R6: set wins over clear in the same cycle
    sda_in = 1'b0; cyc(4); sda_in = 1'b1; cyc(3);
    for (int k = 0; k < FT; k++) tick_once();
    @(negedge clk) begin tick = 1'b1; flag_clr = 1'b1; end
    @(posedge clk);
    @(negedge clk) begin tick = 1'b0; end
    @(posedge clk);
    @(negedge clk) flag_clr = 1'b0;
    check("R6 set beats clear", stop_flag, 1);
    clear_flags();

    // R5: detection disabled
    free_en = 1'b0;
    sda_in = 1'b0; cyc(4); sda_in = 1'b1; cyc(3);
    cnt = 0;
    for (int k = 0; k < FT + 6; k++) begin tick_once(); if (free_evt) cnt++; end
    check("R5 no event when disabled", cnt, 0);
    check("R5 stop_flag", stop_flag, 0);

    // R7 R9: limit sweep
    low_en = 1'b1;
    for (int lim = 1; lim <= 6; lim++) low_case(lim);

    // R7: reload while SCL high
    @(negedge clk) begin low_limit = LW'(6); scl_in = 1'b0; end
    cnt = 0;
    for (int n = 0; n < 5; n++) begin @(posedge clk); @(negedge clk); if (low_evt) cnt++; end
    scl_in = 1'b1;
    for (int n = 0; n < 4; n++) begin @(posedge clk); @(negedge clk); if (low_evt) cnt++; end
    check("R7 no event before reload", cnt, 0);
    low_case(6);

    // R10: zero limit
    @(negedge clk) begin low_limit = '0; scl_in = 1'b0; end
    cnt = 0;
    for (int n = 0; n < 40; n++) begin @(posedge clk); @(negedge clk); if (low_evt) cnt++; end
    check("R10 zero limit", cnt, 0);
    scl_in = 1'b1; cyc(4);

    // R8: low detection disabled
    low_en = 1'b0;
    @(negedge clk) begin low_limit = LW'(3); scl_in = 1'b0; end
    cnt = 0;
    for (int n = 0; n < 20; n++) begin @(posedge clk); @(negedge clk); if (low_evt) cnt++; end
    check("R8 disabled", cnt, 0);
    check("R8 irq", irq, 0);
    scl_in = 1'b1; cyc(4);

    // R11: reset mid-count clears flags
    low_en = 1'b1;
    @(negedge clk) scl_in = 1'b0;
    cyc(8);
    check("R11 pre-reset irq", irq, 1);
    rst_n = 1'b0;
    cyc(2);
    check("R11 irq after reset", irq, 0);
    check("R11 low_evt after reset", low_evt, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule